// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block sits on a byte-wide host bus in front of a 32K x 8 static RAM and takes over the eight highest addresses of that space. Those addresses hold a control byte and seven time bytes. The time bytes are a host-visible copy of a free-running time counter that lives outside the block. Every other address is forwarded to the RAM port unchanged. A read of such an address returns the RAM's data.

The host copy is normally reloaded from the live counter on each one-second strobe. The host sets the hold bit in the control byte to freeze the copy, so that it can read a consistent time while the live counter keeps running. When the host clears the hold bit, the copy is reloaded as a whole on the next cycle and normal tracking resumes.

A supply-fault input deselects the block completely. While it is high, host writes to the clock bytes and all RAM access are blocked, and the read data is not driven.

The copy is controlled by a three-state machine:
- `ST_TRACK` copies the live time on every strobe.
- `ST_HOLD` ignores strobes.
- `ST_RELOAD` is a single cycle that loads all seven bytes.

Its transitions are:
- *freeze*: TRACK to HOLD, on a control write with the hold bit set.
- *release*: HOLD to RELOAD, on a control write with the hold bit clear.
- *resume*: RELOAD to TRACK, taken by default.
- *refreeze*: RELOAD to HOLD, on a control write with the hold bit set.

Top module: `rtc_window`

## Requirements
- R1: After reset, all eight clock bytes read 0x00 and the machine is in tracking mode.
- R2: Address 0x7FF8 is the control byte. Addresses 0x7FF9 through 0x7FFF are, in order, seconds, minutes, hours, day, date, month and year, taken from live_time bytes 0 to 6 (byte k at bits 8k+7:8k). Any address below 0x7FF8 asserts ram_en, forwards addr and wdata, asserts ram_we on a write, and returns ram_rdata on a read.
- R3: In tracking mode, a tick at a clock edge copies all seven live bytes into the host copy, and the new values are readable after that edge.
- R4: Writing the control byte with bit 6 set enters hold mode. Later ticks leave the host copy unchanged.
- R5: Writing the control byte with bit 6 clear while in hold mode loads all seven live bytes at the following clock edge, with no tick needed, and then returns to tracking.
- R6: When a host write to a time byte falls on the same edge as a reload, the written value is kept for that byte and the other six bytes take the live values.
- R7: While supply_bad is 1, writes leave the clock bytes unchanged, ram_en and ram_we stay 0, and rdata_oe stays 0. Tick-driven reloads still take place.
- R8: rdata_oe is 1 only when cs_n = 0, rd_n = 0, wr_n = 1 and supply_bad = 0.
- R9: The control byte reads back all eight bits last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| supply_bad | input | 1 | Supply out of tolerance; deselects the block |
| tick | input | 1 | One-second update strobe |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| live_time | input | 56 | Live time bytes from the counting chain |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data bus drive enable |
| ram_en | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
A tick-driven reload and a host write to one of the time bytes can land on the same clock edge. The bench provokes this by asserting tick while it writes the minutes byte. It then reads the minutes byte, which must hold the written value, and two neighbouring bytes, which must hold the new live values. A second overlap is a release write followed at once by a reload. Here the bench changes the live bytes while the block is held, so that a stale copy and a fresh copy can be told apart.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RELOAD = 2'd2
    } halt_st_e;
endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec #(
    parameter int ADDR_W = 15,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              supply_bad,
    input  logic [ADDR_W-1:0] addr,
    output logic              clk_hit,
    output logic [IDX_W-1:0]  idx,
    output logic              host_rd,
    output logic              reg_wr,
    output logic              ram_en,
    output logic              ram_we
);
    logic access;

    always_comb begin
        access  = !cs_n && !supply_bad;
        clk_hit = &addr[ADDR_W-1:IDX_W];
        idx     = addr[IDX_W-1:0];
        host_rd = access && !rd_n && wr_n;
        reg_wr  = access && !wr_n && clk_hit;
        ram_en  = access && !clk_hit;
        ram_we  = ram_en && !wr_n;
    end
endmodule

// File: rtl/rtc_halt_fsm.sv
module rtc_halt_fsm
    import rtc_win_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic halt_req,
    input  logic tick,
    output logic load_all,
    output logic halted
);
    halt_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK:  if (ctrl_wr && halt_req)  state_d = ST_HOLD;
            ST_HOLD:   if (ctrl_wr && !halt_req) state_d = ST_RELOAD;
            ST_RELOAD: state_d = (ctrl_wr && halt_req) ? ST_HOLD : ST_TRACK;
            default:   state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_comb begin
        load_all = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            ST_TRACK:  load_all = tick;
            ST_HOLD:   halted   = 1'b1;
            ST_RELOAD: load_all = 1'b1;
            default:   load_all = 1'b0;
        endcase
    end

    // R4
    freeze_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && halt_req) |=> !load_all);

    // R5
    release_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && ctrl_wr && !halt_req) |=> load_all);

    // R5
    reload_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOAD && !(ctrl_wr && halt_req)) |=> (state_q == ST_TRACK));
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank #(
    parameter int DATA_W = 8,
    parameter int NREG   = 8,
    localparam int IDX_W  = $clog2(NREG),
    localparam int LIVE_W = (NREG - 1) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_all,
    input  logic [LIVE_W-1:0] live,
    output logic [DATA_W-1:0] rd_byte
);
    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_byte
        if (k == 0) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (!rst_n)                          regs_q[k] <= '0;
                else if (reg_wr && idx == IDX_W'(k)) regs_q[k] <= wdata;
            end
        end else begin : g_time
            always_ff @(posedge clk) begin
                if (!rst_n)                          regs_q[k] <= '0;
                else if (reg_wr && idx == IDX_W'(k)) regs_q[k] <= wdata;
                else if (load_all)                   regs_q[k] <= live[(k-1)*DATA_W +: DATA_W];
            end

            // R6
            host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && idx == IDX_W'(k)) |=> (regs_q[k] == $past(wdata)));

            // R3
            refresh_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load_all && !(reg_wr && idx == IDX_W'(k)))
                    |=> (regs_q[k] == $past(live[(k-1)*DATA_W +: DATA_W])));
        end
    end

    assign rd_byte = regs_q[idx];
endmodule

// File: rtl/rtc_window.sv
module rtc_window #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int NREG     = 8,
    parameter int HALT_BIT = 6,
    localparam int IDX_W  = $clog2(NREG),
    localparam int LIVE_W = (NREG - 1) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              supply_bad,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LIVE_W-1:0] live_time,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    logic             clk_hit, host_rd, reg_wr, load_all, halted, ctrl_wr;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] bank_rd;

    rtc_addr_dec #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .supply_bad(supply_bad),
        .addr(addr), .clk_hit(clk_hit), .idx(idx), .host_rd(host_rd),
        .reg_wr(reg_wr), .ram_en(ram_en), .ram_we(ram_we)
    );

    assign ctrl_wr = reg_wr && (idx == '0);

    rtc_halt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .halt_req(wdata[HALT_BIT]),
        .tick(tick), .load_all(load_all), .halted(halted)
    );

    rtc_user_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .idx(idx), .wdata(wdata),
        .load_all(load_all), .live(live_time), .rd_byte(bank_rd)
    );

    assign rdata     = clk_hit ? bank_rd : ram_rdata;
    assign rdata_oe  = host_rd;
    assign ram_addr  = addr;
    assign ram_wdata = wdata;

    // R7
    fault_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_bad |=> $stable(u_bank.regs_q[0]));

    // R4
    hold_keeps_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !reg_wr) |=> $stable(u_bank.regs_q[1]));
endmodule

// File: tb/sim_rtc_window.sv
module sim_rtc_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, supply_bad = 1'b0, tick = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0, ram_rdata = '0;
    logic [55:0] live_time = '0;
    logic [7:0]  rdata, ram_wdata;
    logic        rdata_oe, ram_en, ram_we;
    logic [14:0] ram_addr;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_window u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .supply_bad(supply_bad), .tick(tick), .addr(addr), .wdata(wdata),
        .live_time(live_time), .rdata(rdata), .rdata_oe(rdata_oe),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-check, 2 idle
        logic        tk;
        logic [14:0] ad;
        logic [7:0]  wd;
        logic [7:0]  seed;
        logic [7:0]  ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 1'b1, 15'h0000, 8'h00, 8'h10, 8'h00, 4'd3},
        '{2'd1, 1'b0, 15'h7FF9, 8'h00, 8'h10, 8'h10, 4'd3},
        '{2'd1, 1'b0, 15'h7FFF, 8'h00, 8'h10, 8'h16, 4'd3},
        '{2'd0, 1'b0, 15'h7FF8, 8'h40, 8'h10, 8'h00, 4'd4},
        '{2'd2, 1'b1, 15'h0000, 8'h00, 8'h20, 8'h00, 4'd4},
        '{2'd1, 1'b0, 15'h7FFA, 8'h00, 8'h20, 8'h11, 4'd4},
        '{2'd1, 1'b0, 15'h7FF8, 8'h00, 8'h20, 8'h40, 4'd9},
        '{2'd0, 1'b0, 15'h7FF8, 8'h05, 8'h30, 8'h00, 4'd5},
        '{2'd2, 1'b0, 15'h0000, 8'h00, 8'h30, 8'h00, 4'd5},
        '{2'd1, 1'b0, 15'h7FFB, 8'h00, 8'h30, 8'h32, 4'd5},
        '{2'd1, 1'b0, 15'h7FF8, 8'h00, 8'h30, 8'h05, 4'd9},
        '{2'd0, 1'b1, 15'h7FFA, 8'h59, 8'h50, 8'h00, 4'd6},
        '{2'd1, 1'b0, 15'h7FFA, 8'h00, 8'h50, 8'h59, 4'd6},
        '{2'd1, 1'b0, 15'h7FF9, 8'h00, 8'h50, 8'h50, 4'd6},
        '{2'd1, 1'b0, 15'h7FFC, 8'h00, 8'h50, 8'h53, 4'd6}
    };

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_live(input logic [7:0] seed);
        for (int k = 0; k < 7; k++) live_time[k*8 +: 8] = seed + 8'(k);
    endtask

    task automatic bus_idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; tick = 1'b0;
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_idle();
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic do_read(input logic [14:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        bus_idle();
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = rdata; oe = rdata_oe;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_read(15'h7FF8, d, oe); check("R1 ctrl", {8'h0, d}, 16'h0000);
        do_read(15'h7FFC, d, oe); check("R1 day",  {8'h0, d}, 16'h0000);
        do_read(15'h7FFF, d, oe); check("R1 year", {8'h0, d}, 16'h0000);

        // Table walk: R3, R4, R5, R6, R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_idle();
            set_live(TBL[i].seed);
            tick  = TBL[i].tk;
            addr  = TBL[i].ad;
            wdata = TBL[i].wd;
            if (TBL[i].op == 2'd0) begin
                cs_n = 1'b0; wr_n = 1'b0;
            end else if (TBL[i].op == 2'd1) begin
                cs_n = 1'b0; rd_n = 1'b0;
            end
            #1;
            if (TBL[i].op == 2'd1) begin
                check($sformatf("R%0d row%0d", TBL[i].rq, i), {8'h0, rdata}, {8'h0, TBL[i].ex});
                check($sformatf("R%0d row%0d oe", TBL[i].rq, i), {15'h0, rdata_oe}, 16'h0001);
            end
        end
        @(negedge clk);
        bus_idle();

        // R2: RAM pass-through
        ram_rdata = 8'hA5;
        do_read(15'h1234, d, oe);
        check("R2 ram read", {8'h0, d}, 16'h00A5);
        check("R2 ram strobes", {13'h0, ram_en, ram_we, oe}, 16'h0005);
        check("R2 ram addr", {1'b0, ram_addr}, 16'h1234);
        @(negedge clk);
        bus_idle();
        cs_n = 1'b0; wr_n = 1'b0; addr = 15'h7FF7; wdata = 8'h3C;
        #1;
        check("R2 ram write", {6'h0, ram_en, ram_we, ram_wdata}, 16'h033C);
        do_read(15'h7FF7, d, oe);
        check("R2 boundary read", {8'h0, d}, 16'h00A5);

        // R7: supply fault blocks access
        @(negedge clk);
        bus_idle();
        supply_bad = 1'b1;
        cs_n = 1'b0; wr_n = 1'b0; addr = 15'h7FF8; wdata = 8'h40;
        #1;
        check("R7 ram blocked", {14'h0, ram_en, ram_we}, 16'h0000);
        do_write(15'h7FFA, 8'h00);
        do_read(15'h7FF8, d, oe);
        check("R7 oe blocked", {15'h0, oe}, 16'h0000);
        @(negedge clk);
        bus_idle();
        supply_bad = 1'b0;
        do_read(15'h7FF8, d, oe); check("R7 ctrl kept",   {8'h0, d}, 16'h0005);
        do_read(15'h7FFA, d, oe); check("R7 minute kept", {8'h0, d}, 16'h0059);

        // R8: drive enable gating
        @(negedge clk);
        bus_idle();
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 15'h0100; wdata = 8'h00;
        #1;
        check("R8 write active", {15'h0, rdata_oe}, 16'h0000);
        @(negedge clk);
        bus_idle();
        rd_n = 1'b0; addr = 15'h7FF8;
        #1;
        check("R8 deselected", {15'h0, rdata_oe}, 16'h0000);

        // R9: full control byte readback
        do_write(15'h7FF8, 8'hBF);
        do_read(15'h7FF8, d, oe); check("R9 ctrl bits", {8'h0, d}, 16'h00BF);

        // R4: hold via 0xFF then tick ignored
        do_write(15'h7FF8, 8'hFF);
        @(negedge clk);
        set_live(8'h80); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        do_read(15'h7FFD, d, oe); check("R4 held date", {8'h0, d}, 16'h0054);

        @(negedge clk);
        bus_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule